// File: doc/BRIEF.md
# Multi-map I2C slave register engine

This block is the bus-facing slave of a device that splits its settings into several independent register maps. Each map answers at its own 7-bit bus address. The block samples SCL and SDA with the system clock and passes them through a synchroniser. It finds START and STOP conditions in any state of a transfer and compares the address byte with its table of map addresses. It then accepts an 8-bit register subaddress and moves data bytes into or out of the selected map, with the subaddress advancing after every byte. The block drives SDA only by pulling it low, through an output-enable.

A host writes a map address, a subaddress and any number of data bytes. To read, it writes the map address and subaddress, issues a repeated START and sends the map address with the read bit set. Two cases end a transfer with a refusal: a subaddress the map does not contain, and a write that sets the reset bit. In the reset case the engine clears itself before it would acknowledge. It then stays deaf to the bus for a programmable number of clock cycles, which stands in for a reset time of a few milliseconds.

Top module: `i2c_mmap_slave`

## Requirements
- R1: After reset, `sda_oe` is low. Register s of map m holds (m*16 + s) mod 256, with 16 registers per map.
- R2: The 7-bit addresses 0x20, 0x22, 0x26 and 0x34 select maps 0, 1, 2 and 3. These are the address bytes 0x40/0x41, 0x44/0x45, 0x4C/0x4D and 0x68/0x69, where bit 0 is the read flag. A match is acknowledged by holding SDA low for the ninth clock. Any other address gets no acknowledge, and the engine ignores the bus until the next START.
- R3: A subaddress from 0 to 15 is acknowledged. A subaddress of 16 or above gets no acknowledge, returns the engine to idle and writes nothing.
- R4: In a write, each data byte is stored at the current subaddress and acknowledged. The subaddress then advances, wrapping from 15 to 0.
- R5: After a repeated START with the read flag set, bytes are sent MSB first, starting at the current subaddress. Each host acknowledge advances the subaddress, wrapping from 15 to 0. A host NACK ends the read.
- R6: A START in any state abandons the transfer and begins a new address phase. A partly received byte is never stored.
- R7: A STOP in any state returns the engine to idle. A partly received byte is discarded.
- R8: A STOP followed by a START within a single SCL high period are both honoured. The address that follows is served normally.
- R9: A data byte with bit 7 set, written to subaddress 15 of map 0, is not acknowledged. It restores every register to its reset value.
- R10: For RST_CYCLES clock cycles after that byte, the engine ignores the bus and acknowledges no address.
- R11: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | High pulls SDA low |

## Verification
Two bus conditions can fall into the same SCL high period: a STOP that ends one transfer and a START that opens the next. The engine must not merge them or lose the second. The bench first completes a write. It then holds SCL high, raises SDA and lowers it again, and sends a new address, subaddress and data byte with no SCL pulse between the two conditions. The case passes when the new address is acknowledged and a later read returns the new byte. A second overlap is the eighth rising edge of the reset byte, which both finishes a data byte and fires the reset. It passes when no acknowledge follows, the next address is refused, and the defaults come back.

// File: rtl/i2c_mmap_pkg.sv
package i2c_mmap_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_SUB,
    ST_WDATA,
    ST_RDATA,
    ST_RACK,
    ST_ACK,
    ST_SWRST
  } eng_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det,
  output logic sda_s
);
  logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
      scl_q  <= scl_ff[SYNC_STAGES-1];
      sda_q  <= sda_ff[SYNC_STAGES-1];
    end
  end

  assign sda_s     = sda_ff[SYNC_STAGES-1];
  assign scl_rise  =  scl_ff[SYNC_STAGES-1] & ~scl_q;
  assign scl_fall  = ~scl_ff[SYNC_STAGES-1] &  scl_q;
  // a data edge seen while the clock line stays high frames a transfer
  assign start_det =  scl_ff[SYNC_STAGES-1] & scl_q &  sda_q & ~sda_s;
  assign stop_det  =  scl_ff[SYNC_STAGES-1] & scl_q & ~sda_q &  sda_s;
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match #(
  parameter int                    NUM_MAPS  = 4,
  parameter logic [NUM_MAPS*7-1:0] MAP_ADDRS = {7'h34, 7'h26, 7'h22, 7'h20},
  parameter int                    MAP_W     = 2
) (
  input  logic [6:0]       addr,
  output logic             hit,
  output logic [MAP_W-1:0] idx
);
  logic [NUM_MAPS-1:0] hit_vec;

  for (genvar m = 0; m < NUM_MAPS; m++) begin : g_cmp
    assign hit_vec[m] = (addr == MAP_ADDRS[m*7 +: 7]);
  end

  always_comb begin
    idx = '0;
    for (int m = NUM_MAPS - 1; m >= 0; m--) begin
      if (hit_vec[m]) idx = MAP_W'(m);
    end
  end

  assign hit = |hit_vec;
endmodule

// File: rtl/i2c_regbank.sv
module i2c_regbank #(
  parameter int NUM_MAPS = 4,
  parameter int DEPTH    = 16,
  parameter int MAP_W    = 2,
  parameter int SUB_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             we,
  input  logic [MAP_W-1:0] map_sel,
  input  logic [SUB_W-1:0] sub_sel,
  input  logic [7:0]       wr_data,
  output logic [7:0]       rd_data
);
  logic [7:0] mem [NUM_MAPS][DEPTH];

  function automatic logic [7:0] dflt(input int m, input int s);
    return 8'((m * DEPTH + s) % 256);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int m = 0; m < NUM_MAPS; m++)
        for (int s = 0; s < DEPTH; s++) mem[m][s] <= dflt(m, s);
    end else if (clr) begin
      for (int m = 0; m < NUM_MAPS; m++)
        for (int s = 0; s < DEPTH; s++) mem[m][s] <= dflt(m, s);
    end else if (we) begin
      mem[map_sel][sub_sel] <= wr_data;
    end
  end

  assign rd_data = mem[map_sel][sub_sel];
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import i2c_mmap_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int MAP_W      = 2,
  parameter int SUB_W      = 4,
  parameter int RST_CYCLES = 200000,
  parameter int RST_SUB    = 15,
  parameter int RST_BIT    = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic             sda_s,
  output logic [6:0]       cand_addr,
  input  logic             addr_hit,
  input  logic [MAP_W-1:0] addr_idx,
  output logic             reg_we,
  output logic             reg_clr,
  output logic [MAP_W-1:0] reg_map,
  output logic [SUB_W-1:0] reg_sub,
  output logic [7:0]       reg_wdata,
  input  logic [7:0]       reg_rdata,
  output logic             sda_oe
);
  localparam int RC_W = $clog2(RST_CYCLES + 1);

  eng_state_e       state_q, state_n, ackn_q, ackn_n;
  logic [2:0]       cnt_q, cnt_n;
  logic [7:0]       sh_q, sh_n, byte_in;
  logic [MAP_W-1:0] map_q, map_n;
  logic [SUB_W-1:0] sub_q, sub_n;
  logic             oe_q, oe_n, ackon_q, ackon_n, gack_q, gack_n;
  logic [RC_W-1:0]  rc_q, rc_n;

  function automatic logic [SUB_W-1:0] sub_inc(input logic [SUB_W-1:0] s);
    return (s == SUB_W'(DEPTH - 1)) ? '0 : s + 1'b1;
  endfunction

  assign byte_in = {sh_q[6:0], sda_s};

  always_comb begin
    state_n = state_q; ackn_n = ackn_q; cnt_n = cnt_q; sh_n = sh_q;
    map_n = map_q; sub_n = sub_q; oe_n = oe_q; ackon_n = ackon_q;
    gack_n = gack_q; rc_n = rc_q; reg_we = 1'b0; reg_clr = 1'b0;
    if (state_q == ST_SWRST) begin
      rc_n = rc_q + 1'b1;
      if (rc_q == RC_W'(RST_CYCLES - 1)) state_n = ST_IDLE;
    end else if (start_det) begin
      state_n = ST_ADDR; cnt_n = '0; oe_n = 1'b0;
    end else if (stop_det) begin
      state_n = ST_IDLE; oe_n = 1'b0;
    end else begin
      case (state_q)
        ST_ADDR, ST_SUB, ST_WDATA: if (scl_rise) begin
          sh_n  = byte_in;
          cnt_n = cnt_q + 1'b1;
          if (cnt_q == 3'd7) begin
            ackon_n = 1'b0;
            ackn_n  = ST_WDATA;
            state_n = ST_ACK;
            if (state_q == ST_ADDR) begin
              map_n = addr_idx;
              ackn_n = sda_s ? ST_RDATA : ST_SUB;
              if (!addr_hit) state_n = ST_IDLE;
            end else if (state_q == ST_SUB) begin
              sub_n = SUB_W'(byte_in);
              if ({1'b0, byte_in} >= 9'(DEPTH)) state_n = ST_IDLE;
            end else if (map_q == '0 && sub_q == SUB_W'(RST_SUB) && byte_in[RST_BIT]) begin
              state_n = ST_SWRST; reg_clr = 1'b1; rc_n = '0;
              map_n = '0; sub_n = '0;
            end else begin
              reg_we = 1'b1; sub_n = sub_inc(sub_q);
            end
          end
        end
        ST_ACK: if (scl_fall) begin
          if (!ackon_q) begin
            oe_n = 1'b1; ackon_n = 1'b1;
          end else begin
            oe_n = 1'b0; state_n = ackn_q; cnt_n = '0;
            if (ackn_q == ST_RDATA) begin
              sh_n = reg_rdata; oe_n = ~reg_rdata[7];
            end
          end
        end
        ST_RDATA: if (scl_rise) begin
          cnt_n = cnt_q + 1'b1;
          if (cnt_q == 3'd7) begin state_n = ST_RACK; gack_n = 1'b0; end
        end else if (scl_fall) begin
          sh_n = {sh_q[6:0], 1'b0}; oe_n = ~sh_q[6];
        end
        ST_RACK: if (scl_rise) begin
          if (!sda_s) begin gack_n = 1'b1; sub_n = sub_inc(sub_q); end
          else state_n = ST_IDLE;
        end else if (scl_fall) begin
          if (gack_q) begin
            sh_n = reg_rdata; oe_n = ~reg_rdata[7]; state_n = ST_RDATA; cnt_n = '0;
          end else oe_n = 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; ackn_q <= ST_IDLE; cnt_q <= '0; sh_q <= '0;
      map_q <= '0; sub_q <= '0; oe_q <= 1'b0; ackon_q <= 1'b0;
      gack_q <= 1'b0; rc_q <= '0;
    end else begin
      state_q <= state_n; ackn_q <= ackn_n; cnt_q <= cnt_n; sh_q <= sh_n;
      map_q <= map_n; sub_q <= sub_n; oe_q <= oe_n; ackon_q <= ackon_n;
      gack_q <= gack_n; rc_q <= rc_n;
    end
  end

  assign cand_addr = sh_q[6:0];
  assign reg_map   = map_q;
  assign reg_sub   = sub_q;
  assign reg_wdata = byte_in;
  assign sda_oe    = oe_q;

  // R6
  start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && state_q != ST_SWRST) |=> state_q == ST_ADDR);
  // R7
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && state_q != ST_SWRST) |=> state_q == ST_IDLE);
  // R11
  oe_fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_fall && !start_det && !stop_det) |=> $stable(sda_oe));
  // R10
  swrst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SWRST) |-> !sda_oe);
  // R9
  swrst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_clr |=> (state_q == ST_SWRST && !sda_oe));
endmodule

// File: rtl/i2c_mmap_slave.sv
module i2c_mmap_slave #(
  parameter int                    NUM_MAPS   = 4,
  parameter logic [NUM_MAPS*7-1:0] MAP_ADDRS  = {7'h34, 7'h26, 7'h22, 7'h20},
  parameter int                    DEPTH      = 16,
  parameter int                    RST_CYCLES = 200000,
  parameter int                    RST_SUB    = 15,
  parameter int                    RST_BIT    = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  localparam int MAP_W = (NUM_MAPS > 1) ? $clog2(NUM_MAPS) : 1;
  localparam int SUB_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [1:0]       rst_ff;
  logic             rst_s_n;
  logic             scl_rise, scl_fall, start_det, stop_det, sda_s;
  logic [6:0]       cand_addr;
  logic             addr_hit, reg_we, reg_clr;
  logic [MAP_W-1:0] addr_idx, reg_map;
  logic [SUB_W-1:0] reg_sub;
  logic [7:0]       reg_wdata, reg_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff <= 2'b00;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_s_n = rst_ff[1];

  i2c_line_sync #(.SYNC_STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_s_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .sda_s(sda_s));

  i2c_addr_match #(.NUM_MAPS(NUM_MAPS), .MAP_ADDRS(MAP_ADDRS), .MAP_W(MAP_W)) u_match (
    .addr(cand_addr), .hit(addr_hit), .idx(addr_idx));

  i2c_slave_fsm #(.DEPTH(DEPTH), .MAP_W(MAP_W), .SUB_W(SUB_W),
    .RST_CYCLES(RST_CYCLES), .RST_SUB(RST_SUB), .RST_BIT(RST_BIT)) u_fsm (
    .clk(clk), .rst_n(rst_s_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s),
    .cand_addr(cand_addr), .addr_hit(addr_hit), .addr_idx(addr_idx),
    .reg_we(reg_we), .reg_clr(reg_clr), .reg_map(reg_map), .reg_sub(reg_sub),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sda_oe(sda_oe));

  i2c_regbank #(.NUM_MAPS(NUM_MAPS), .DEPTH(DEPTH), .MAP_W(MAP_W), .SUB_W(SUB_W)) u_regs (
    .clk(clk), .rst_n(rst_s_n), .clr(reg_clr), .we(reg_we), .map_sel(reg_map),
    .sub_sel(reg_sub), .wr_data(reg_wdata), .rd_data(reg_rdata));
endmodule

// File: tb/i2c_mmap_slave_tb.sv
module i2c_mmap_slave_tb;
  localparam int HP   = 10;
  localparam int RSTC = 2000;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic sda_oe, sda_line;
  assign sda_line = sda_m & ~sda_oe;

  i2c_mmap_slave #(.RST_CYCLES(RSTC)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe));

  always #5 clk = ~clk;

  int checks = 0, errors = 0, oe_bad = 0;
  logic oe_prev = 1'b0;
  logic [7:0] model [4][16];
  logic [7:0] wbuf [16];
  logic [6:0] maddr [4] = '{7'h20, 7'h22, 7'h26, 7'h34};

  // R11 monitor: enable must not move while the clock line is high
  always @(negedge clk) begin
    if (rst_n && scl && sda_oe !== oe_prev) oe_bad++;
    oe_prev = sda_oe;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hw();
    repeat (HP) @(negedge clk);
  endtask
  task automatic bstart();
    sda_m = 1'b1; hw(); scl = 1'b1; hw(); sda_m = 1'b0; hw(); scl = 1'b0;
  endtask
  task automatic bstop();
    sda_m = 1'b0; hw(); scl = 1'b1; hw(); sda_m = 1'b1; hw();
  endtask
  task automatic wbit(input logic b);
    sda_m = b; hw(); scl = 1'b1; hw(); scl = 1'b0;
  endtask
  task automatic rbit(output logic b);
    sda_m = 1'b1; hw(); scl = 1'b1;
    repeat (HP / 2) @(negedge clk);
    b = sda_line;
    repeat (HP - HP / 2) @(negedge clk);
    scl = 1'b0;
  endtask
  task automatic send(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(b);
    ack = ~b;
  endtask
  task automatic recv(output logic [7:0] v, input logic mack);
    logic b;
    for (int i = 7; i >= 0; i--) begin rbit(b); v[i] = b; end
    wbit(~mack);
  endtask

  task automatic do_write(input int m, input int sub, input int n, input string req);
    logic ack;
    bstart();
    send({maddr[m], 1'b0}, ack); check({req, " addr ack"}, ack, 1);
    send(8'(sub), ack);          check({req, " sub ack"}, ack, 1);
    for (int k = 0; k < n; k++) begin
      send(wbuf[k], ack); check({req, " data ack"}, ack, 1);
      model[m][(sub + k) % 16] = wbuf[k];
    end
    bstop();
  endtask

  task automatic do_read(input int m, input int sub, input int n, input string req);
    logic ack;
    logic [7:0] v;
    bstart();
    send({maddr[m], 1'b0}, ack); check({req, " addr ack"}, ack, 1);
    send(8'(sub), ack);          check({req, " sub ack"}, ack, 1);
    bstart();
    send({maddr[m], 1'b1}, ack); check({req, " raddr ack"}, ack, 1);
    for (int k = 0; k < n; k++) begin
      recv(v, k < n - 1);
      check({req, " data"}, v, model[m][(sub + k) % 16]);
    end
    bstop();
  endtask

  task automatic set_defaults();
    for (int m = 0; m < 4; m++)
      for (int s = 0; s < 16; s++) model[m][s] = 8'(m * 16 + s);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic ack;
    int exp;
    set_defaults();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check("R1 oe after reset", sda_oe, 0);

    // R1 / R5: every default read back through burst reads
    for (int m = 0; m < 4; m++) do_read(m, 0, 16, "R1");

    // R4 / R5: full write sweep then read back, including wrap on read
    for (int m = 0; m < 4; m++) begin
      for (int k = 0; k < 16; k++) wbuf[k] = 8'((m * 53 + k * 29 + 7) & 8'h7F);
      do_write(m, 0, 16, "R4");
      do_read(m, 0, 16, "R5");
    end
    do_read(2, 9, 10, "R5 wrap");
    for (int k = 0; k < 4; k++) wbuf[k] = 8'(8'h50 + k);
    do_write(1, 14, 4, "R4 wrap");
    do_read(1, 13, 6, "R4 wrap readback");

    // R2: sweep every 7-bit address
    for (int a = 0; a < 128; a++) begin
      exp = (a == 'h20 || a == 'h22 || a == 'h26 || a == 'h34) ? 1 : 0;
      bstart();
      send({7'(a), 1'b0}, ack);
      check("R2 address ack", ack, exp);
      bstop();
    end

    // R3: out-of-range subaddresses are refused and nothing is stored
    for (int m = 0; m < 4; m++) begin
      foreach (wbuf[i]) wbuf[i] = 8'(16 + i * 37);
      for (int j = 0; j < 4; j++) begin
        bstart();
        send({maddr[m], 1'b0}, ack); check("R3 addr ack", ack, 1);
        send(wbuf[j] | 8'h10, ack);  check("R3 bad sub nack", ack, 0);
        send(8'h3C, ack);            check("R3 data after bad sub nack", ack, 0);
        bstop();
      end
      do_read(m, 0, 16, "R3 unchanged");
    end

    // R6: START in the middle of a data byte
    bstart();
    send({maddr[2], 1'b0}, ack); check("R6 addr ack", ack, 1);
    send(8'd3, ack);             check("R6 sub ack", ack, 1);
    for (int i = 0; i < 4; i++) wbit(1'b1);
    bstart();
    send({maddr[2], 1'b0}, ack); check("R6 restart addr ack", ack, 1);
    bstop();
    do_read(2, 3, 1, "R6 unchanged");

    // R7: STOP in the middle of a data byte
    bstart();
    send({maddr[3], 1'b0}, ack); check("R7 addr ack", ack, 1);
    send(8'd5, ack);             check("R7 sub ack", ack, 1);
    for (int i = 0; i < 5; i++) wbit(1'b0);
    bstop();
    do_read(3, 5, 1, "R7 unchanged");

    // R8: STOP then START inside one SCL high period
    bstart();
    send({maddr[0], 1'b0}, ack); check("R8 addr ack", ack, 1);
    send(8'd2, ack);             check("R8 sub ack", ack, 1);
    send(8'h11, ack);            check("R8 data ack", ack, 1);
    model[0][2] = 8'h11;
    sda_m = 1'b0; hw(); scl = 1'b1; hw(); sda_m = 1'b1; hw(); sda_m = 1'b0; hw(); scl = 1'b0;
    send({maddr[0], 1'b0}, ack); check("R8 addr after stop-start", ack, 1);
    send(8'd2, ack);             check("R8 sub after stop-start", ack, 1);
    send(8'h66, ack);            check("R8 data after stop-start", ack, 1);
    model[0][2] = 8'h66;
    bstop();
    do_read(0, 2, 1, "R8 readback");

    // R9 / R10: software reset byte
    bstart();
    send({maddr[0], 1'b0}, ack); check("R9 addr ack", ack, 1);
    send(8'd15, ack);            check("R9 sub ack", ack, 1);
    send(8'h80, ack);            check("R9 reset byte nack", ack, 0);
    bstart();
    send({maddr[1], 1'b0}, ack); check("R10 ignored during reset", ack, 0);
    bstop();
    repeat (RSTC + 100) @(negedge clk);
    check("R10 oe idle after reset", sda_oe, 0);
    set_defaults();
    for (int m = 0; m < 4; m++) do_read(m, 0, 16, "R9 defaults");

    check("R11 oe moved with SCL high", oe_bad, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule